// File: doc/BRIEF.md
# Bus-Attached Compare Timer

This block is a 32-bit free-running up-counter that a small processor reaches through a request/grant/response memory bus. Software turns counting on and off, loads a match value, reads or reloads the running count, and gets a level interrupt when the count meets the match value. The interrupt stays raised until software acknowledges it through the control word.

The block answers only inside its own 16-byte window at base 0x700. Each request that hits the window is granted in the cycle it is presented, and one response comes back in the next cycle. Responses to requests issued on consecutive cycles come back in the same order. The response path is a three-state machine: `RSP_IDLE` (no response pending), `RSP_OK` (a good response with data) and `RSP_ERR` (an error response with zero data). From any state, an accepted request to a mapped, aligned word moves it to `RSP_OK`. An accepted request to the unmapped word or to a misaligned address moves it to `RSP_ERR`. A cycle with no accepted request moves it to `RSP_IDLE`.

Top module: `cmp_timer`

## Requirements
- R1: A request whose address bits [31:4] equal 0x70 is granted (`bus_gnt_o` high) in the same cycle. Any other address is never granted and gets no response.
- R2: Every accepted request (req and gnt high at a clock edge) produces exactly one `bus_rvalid_o` pulse in the following cycle. Requests on back-to-back cycles are answered in issue order.
- R3: Word offset 0x0 is the control word (bit 0 enable, bit 1 IRQ pending, all other bits read 0). Offset 0x4 is the compare value and offset 0x8 is the counter. A read returns the value held just before the accepting edge.
- R4: On a write, byte lane i (bits 8i+7..8i) changes only when `bus_be_i[i]` is set. Both control bits live in lane 0.
- R5: An access to offset 0xC, or to any address with bits [1:0] not zero, returns `bus_err_o` high with zero read data and changes no register.
- R6: While enable is 1 the counter increases by one every clock cycle. While enable is 0 it holds its value.
- R7: A write to the counter loads the written bytes and overrides that cycle's increment. Counting continues from the loaded value.
- R8: The counter wraps from 0xFFFFFFFF to 0.
- R9: The pending flag sets at the edge where enable is 1 and the counter equals the compare value. `irq_o` equals the pending flag.
- R10: Writing control with lane 0 enabled and bit 1 = 1 clears pending. Writing bit 1 = 0 leaves pending unchanged.
- R11: If a clear write and a match fall on the same edge, pending ends up set.
- R12: After reset, all registers read 0, `irq_o` is low and `bus_rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Request valid |
| bus_addr_i | input | 32 | Byte address of the request |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_be_i | input | 4 | Byte lane enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_gnt_o | output | 1 | Request accepted this cycle |
| bus_rvalid_o | output | 1 | Response valid, one cycle per accepted request |
| bus_rdata_o | output | 32 | Read data of the response |
| bus_err_o | output | 1 | Error flag of the response |
| irq_o | output | 1 | Level interrupt, follows the pending flag |

## Verification
The bench lines a clear write up with the exact edge of a compare match. A design that lets the clear win would drop an interrupt that software never saw. It also checks the cycle before a match, so a design that compares against the next count would raise the interrupt one cycle early. Counter values are predicted from the accepting edges of the enable and read requests, which exposes an off-by-one in when counting starts, a lost increment at the wrap, and a load that does not override the increment. Partial-lane writes, the unmapped word and back-to-back reads catch lane-merge mistakes, side effects from error accesses, and responses that come back shifted or swapped.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_OK,
        RSP_ERR
    } rsp_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_CMP,
        SEL_CNT,
        SEL_NONE
    } reg_sel_e;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_PEND_BIT = 1;

endpackage

// File: rtl/ctmr_decode.sv
module ctmr_decode
    import ctmr_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 32,
    parameter int unsigned          WIN_BITS  = 4,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 32'h0000_0700
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic              bad_o,
    output reg_sel_e          sel_o
);
    localparam int unsigned IDX_W = WIN_BITS - 2;

    logic [IDX_W-1:0] word_idx;

    assign hit_o    = (addr_i[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
    assign word_idx = addr_i[WIN_BITS-1:2];

    always_comb begin
        if (addr_i[1:0] != 2'b00) begin
            sel_o = SEL_NONE;
        end else begin
            case (word_idx)
                IDX_W'(0): sel_o = SEL_CTRL;
                IDX_W'(1): sel_o = SEL_CMP;
                IDX_W'(2): sel_o = SEL_CNT;
                default:   sel_o = SEL_NONE;
            endcase
        end
    end

    assign bad_o = (sel_o == SEL_NONE);

endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_ctrl_i,
    input  logic                wr_cmp_i,
    input  logic                wr_cnt_i,
    input  logic [DATA_W/8-1:0] be_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic                en_o,
    output logic                pend_o,
    output logic [DATA_W-1:0]   cmp_o,
    output logic [DATA_W-1:0]   cnt_o
);
    localparam int unsigned BE_W = DATA_W / 8;

    logic [DATA_W-1:0] cmp_q, cnt_q;
    logic [DATA_W-1:0] cmp_merged, cnt_merged;
    logic              en_q, pend_q;
    logic              match, clr_req, ctrl_lane0;

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign cmp_merged[b*8 +: 8] = be_i[b] ? wdata_i[b*8 +: 8] : cmp_q[b*8 +: 8];
        assign cnt_merged[b*8 +: 8] = be_i[b] ? wdata_i[b*8 +: 8] : cnt_q[b*8 +: 8];
    end

    assign ctrl_lane0 = wr_ctrl_i && be_i[0];
    assign match      = en_q && (cnt_q == cmp_q);
    assign clr_req    = ctrl_lane0 && wdata_i[CTRL_PEND_BIT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= 1'b0;
        end else if (ctrl_lane0) begin
            en_q <= wdata_i[CTRL_EN_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
        end else if (match) begin
            pend_q <= 1'b1;
        end else if (clr_req) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmp_q <= '0;
        end else if (wr_cmp_i) begin
            cmp_q <= cmp_merged;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (wr_cnt_i) begin
            cnt_q <= cnt_merged;
        end else if (en_q) begin
            cnt_q <= cnt_q + DATA_W'(1);
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign cmp_o  = cmp_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/ctmr_resp.sv
module ctmr_resp
    import ctmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              acc_i,
    input  logic              bad_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic              rvalid_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o
);
    rsp_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_OK, RSP_ERR: begin
                if (acc_i) begin
                    state_d = bad_i ? RSP_ERR : RSP_OK;
                end else begin
                    state_d = RSP_IDLE;
                end
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RSP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (acc_i) begin
                data_q <= bad_i ? '0 : rd_word_i;
            end
        end
    end

    always_comb begin
        rvalid_o = 1'b0;
        err_o    = 1'b0;
        rdata_o  = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_OK: begin
                rvalid_o = 1'b1;
                rdata_o  = data_q;
            end
            RSP_ERR: begin
                rvalid_o = 1'b1;
                err_o    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import ctmr_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       WIN_BITS  = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_0700
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_req_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_we_i,
    input  logic [DATA_W/8-1:0] bus_be_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic                bus_gnt_o,
    output logic                bus_rvalid_o,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                bus_err_o,
    output logic                irq_o
);
    logic              win_hit, acc_bad, acc;
    reg_sel_e          sel;
    logic              wr_ctrl, wr_cmp, wr_cnt;
    logic              tmr_en, tmr_pend;
    logic [DATA_W-1:0] tmr_cmp, tmr_cnt, rd_word;

    ctmr_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .BASE_ADDR(BASE_ADDR)
    ) i_decode (
        .addr_i(bus_addr_i),
        .hit_o (win_hit),
        .bad_o (acc_bad),
        .sel_o (sel)
    );

    assign bus_gnt_o = bus_req_i && win_hit;
    assign acc       = bus_gnt_o;

    assign wr_ctrl = acc && bus_we_i && (sel == SEL_CTRL);
    assign wr_cmp  = acc && bus_we_i && (sel == SEL_CMP);
    assign wr_cnt  = acc && bus_we_i && (sel == SEL_CNT);

    ctmr_regs #(
        .DATA_W(DATA_W)
    ) i_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_ctrl_i(wr_ctrl),
        .wr_cmp_i (wr_cmp),
        .wr_cnt_i (wr_cnt),
        .be_i     (bus_be_i),
        .wdata_i  (bus_wdata_i),
        .en_o     (tmr_en),
        .pend_o   (tmr_pend),
        .cmp_o    (tmr_cmp),
        .cnt_o    (tmr_cnt)
    );

    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_CTRL: begin
                rd_word[CTRL_EN_BIT]   = tmr_en;
                rd_word[CTRL_PEND_BIT] = tmr_pend;
            end
            SEL_CMP:  rd_word = tmr_cmp;
            SEL_CNT:  rd_word = tmr_cnt;
            SEL_NONE: rd_word = '0;
            default:  rd_word = '0;
        endcase
    end

    ctmr_resp #(
        .DATA_W(DATA_W)
    ) i_resp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .acc_i    (acc),
        .bad_i    (acc_bad),
        .rd_word_i(rd_word),
        .rvalid_o (bus_rvalid_o),
        .err_o    (bus_err_o),
        .rdata_o  (bus_rdata_o)
    );

    assign irq_o = tmr_pend;

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                bus_req_i,
    input logic                bus_gnt_o,
    input logic                bus_we_i,
    input logic [DATA_W/8-1:0] bus_be_i,
    input logic [DATA_W-1:0]   bus_wdata_i,
    input logic                bus_rvalid_o,
    input logic                bus_err_o,
    input logic [DATA_W-1:0]   bus_rdata_o,
    input logic                irq_o,
    input logic                en,
    input logic                cnt_wr,
    input logic [DATA_W-1:0]   cnt
);
    // R1: no grant without a request
    a_r1_gnt_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_gnt_o |-> bus_req_i);

    // R2: one response in the cycle after each accepted request
    a_r2_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && bus_gnt_o) |=> bus_rvalid_o);

    // R2: no response without an accepted request
    a_r2_no_stray_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_req_i && bus_gnt_o) |=> !bus_rvalid_o);

    // R5: an error response carries zero data
    a_r5_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rvalid_o && bus_err_o) |-> (bus_rdata_o == '0));

    // R6: the count holds while disabled and not written
    a_r6_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en && !cnt_wr) |=> $stable(cnt));

    // R8: wrap from all ones to zero
    a_r8_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && !cnt_wr && (cnt == {DATA_W{1'b1}})) |=> (cnt == '0));

    // R10: the interrupt only falls after a clear write
    a_r10_fall_by_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> $past(bus_req_i && bus_gnt_o && bus_we_i && bus_be_i[0] && bus_wdata_i[1]));

endmodule

bind cmp_timer cmp_timer_chk #(
    .DATA_W(DATA_W)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_gnt_o   (bus_gnt_o),
    .bus_we_i    (bus_we_i),
    .bus_be_i    (bus_be_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rvalid_o(bus_rvalid_o),
    .bus_err_o   (bus_err_o),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .en          (tmr_en),
    .cnt_wr      (wr_cnt),
    .cnt         (tmr_cnt)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;

    localparam logic [31:0] A_CTRL = 32'h0000_0700;
    localparam logic [31:0] A_CMP  = 32'h0000_0704;
    localparam logic [31:0] A_CNT  = 32'h0000_0708;
    localparam logic [31:0] A_HOLE = 32'h0000_070C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] addr = '0;
    logic        we = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic        gnt, rvalid, err, irq;
    logic [31:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmp_timer i_cmp_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_req_i   (req),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_be_i    (be),
        .bus_wdata_i (wdata),
        .bus_gnt_o   (gnt),
        .bus_rvalid_o(rvalid),
        .bus_rdata_o (rdata),
        .bus_err_o   (err),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // starts and ends at a falling edge; acc_edge is the index of the accepting edge
    task automatic xfer(input logic [31:0] a, input logic w, input logic [3:0] b,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic er, output int acc_edge);
        req = 1'b1; addr = a; we = w; be = b; wdata = d;
        acc_edge = cyc + 1;
        #1;
        check("R1 grant in window", {31'b0, gnt}, 32'd1);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        check("R2 response valid", {31'b0, rvalid}, 32'd1);
        rd = rdata;
        er = err;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, output int e);
        logic [31:0] rd; logic er;
        xfer(a, 1'b1, 4'hF, d, rd, er, e);
    endtask

    task automatic rd_reg(input logic [31:0] a, output logic [31:0] v, output int e);
        logic er;
        xfer(a, 1'b0, 4'h0, 32'h0, v, er, e);
    endtask

    task automatic t_reset;
        logic [31:0] v; int e;
        check("R12 irq low after reset", {31'b0, irq}, 32'd0);
        check("R12 no response after reset", {31'b0, rvalid}, 32'd0);
        rd_reg(A_CTRL, v, e); check("R12 ctrl reset", v, 32'd0);
        rd_reg(A_CMP,  v, e); check("R12 cmp reset",  v, 32'd0);
        rd_reg(A_CNT,  v, e); check("R12 cnt reset",  v, 32'd0);
    endtask

    task automatic t_outside;
        req = 1'b1; addr = 32'h0000_0800; we = 1'b0; be = 4'h0;
        #1;
        check("R1 no grant outside window", {31'b0, gnt}, 32'd0);
        @(negedge clk);
        req = 1'b0;
        check("R1 no response outside window", {31'b0, rvalid}, 32'd0);
    endtask

    task automatic t_lanes;
        logic [31:0] v, rd; logic er; int e;
        wr(A_CMP, 32'h1122_3344, e);
        xfer(A_CMP, 1'b1, 4'b0101, 32'hAABB_CCDD, rd, er, e);
        rd_reg(A_CMP, v, e);
        check("R4 partial lanes", v, 32'h11BB_33DD);
        rd_reg(A_CTRL, v, e);
        check("R3 ctrl reads zero", v, 32'd0);
    endtask

    task automatic t_hole;
        logic [31:0] rd, v; logic er; int e;
        xfer(A_HOLE, 1'b0, 4'h0, 32'h0, rd, er, e);
        check("R5 hole err", {31'b0, er}, 32'd1);
        check("R5 hole data zero", rd, 32'd0);
        xfer(A_HOLE, 1'b1, 4'hF, 32'hFFFF_FFFF, rd, er, e);
        check("R5 hole write err", {31'b0, er}, 32'd1);
        xfer(A_CMP + 32'd1, 1'b1, 4'hF, 32'h0, rd, er, e);
        check("R5 misaligned err", {31'b0, er}, 32'd1);
        rd_reg(A_CMP, v, e);
        check("R5 cmp untouched", v, 32'h11BB_33DD);
        rd_reg(A_CTRL, v, e);
        check("R5 ctrl untouched", v, 32'd0);
    endtask

    task automatic t_count;
        logic [31:0] v; int e0, e1, e2;
        wr(A_CNT, 32'd100, e0);
        repeat (5) @(negedge clk);
        rd_reg(A_CNT, v, e2);
        check("R6 hold while disabled", v, 32'd100);
        wr(A_CTRL, 32'd1, e1);
        rd_reg(A_CNT, v, e2);
        check("R6 first read after enable", v, 32'd100 + 32'(e2 - e1 - 1));
        repeat (7) @(negedge clk);
        rd_reg(A_CNT, v, e2);
        check("R6 count per cycle", v, 32'd100 + 32'(e2 - e1 - 1));
        wr(A_CNT, 32'd5000, e1);
        repeat (3) @(negedge clk);
        rd_reg(A_CNT, v, e2);
        check("R7 load while running", v, 32'd5000 + 32'(e2 - e1 - 1));
        wr(A_CTRL, 32'd2, e1);
    endtask

    task automatic t_wrap;
        logic [31:0] v; int e0, e1, e2;
        wr(A_CNT, 32'hFFFF_FFFE, e0);
        wr(A_CTRL, 32'd1, e1);
        while (cyc < e1 + 2) @(negedge clk);
        rd_reg(A_CNT, v, e2);
        check("R8 wrap", v, 32'hFFFF_FFFE + 32'(e2 - e1 - 1));
        wr(A_CTRL, 32'd2, e1);
    endtask

    task automatic t_irq;
        logic [31:0] v; int e0, e1;
        wr(A_CTRL, 32'd2, e0);
        wr(A_CMP, 32'd1000, e0);
        wr(A_CNT, 32'd990, e0);
        wr(A_CTRL, 32'd1, e1);
        while (cyc < e1 + 10) @(negedge clk);
        check("R9 not raised before match", {31'b0, irq}, 32'd0);
        @(negedge clk);
        check("R9 raised at match", {31'b0, irq}, 32'd1);
        rd_reg(A_CTRL, v, e0);
        check("R9 pending readable", v, 32'd3);
        wr(A_CTRL, 32'd1, e0);
        check("R10 write zero keeps pending", {31'b0, irq}, 32'd1);
        wr(A_CTRL, 32'd3, e0);
        check("R10 write one clears", {31'b0, irq}, 32'd0);
        rd_reg(A_CTRL, v, e0);
        check("R10 enable kept after clear", v, 32'd1);
    endtask

    task automatic t_race;
        int e0, e1;
        wr(A_CTRL, 32'd2, e0);
        wr(A_CMP, 32'd2000, e0);
        wr(A_CNT, 32'd1997, e0);
        wr(A_CTRL, 32'd1, e1);
        while (cyc < e1 + 3) @(negedge clk);
        wr(A_CTRL, 32'd3, e0);
        check("R11 set beats clear", {31'b0, irq}, 32'd1);
        wr(A_CTRL, 32'd2, e0);
        check("R10 clear after race", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_b2b;
        int e;
        wr(A_CMP, 32'hCAFE_0001, e);
        req = 1'b1; addr = A_CMP; we = 1'b0; be = 4'h0;
        @(negedge clk);
        addr = A_CTRL;
        check("R2 first of pair valid", {31'b0, rvalid}, 32'd1);
        check("R2 first of pair data", rdata, 32'hCAFE_0001);
        @(negedge clk);
        req = 1'b0;
        check("R2 second of pair valid", {31'b0, rvalid}, 32'd1);
        check("R2 second of pair data", rdata, 32'd0);
        @(negedge clk);
        check("R2 single pulse", {31'b0, rvalid}, 32'd0);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_outside;
        t_lanes;
        t_hole;
        t_count;
        t_wrap;
        t_irq;
        t_race;
        t_b2b;
        report;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report;
    end

endmodule